// File: doc/BRIEF.md
# Split-Half GPIO Controller with Edge Interrupts

This block is a 32-pin general purpose I/O controller. Software reaches it as 16-bit registers: every 32-bit register is split into a low half (pins 15:0) and a high half (pins 31:16), and the high halves sit at a fixed distance of 0x500 above the low ones. It holds an output register that drives the pins, an input register that follows the synchronised pin levels, and two interrupt enable masks, one for rising edges and one for falling edges. A status register holds the most recent qualifying edge.

When a synchronised input changes level and the enable mask for that direction is set for that pin, the status register is replaced by a one-hot mask of that pin and the interrupt line goes high. Reading the status register returns its value, clears it and drops the interrupt line.

A side function turns a 19-bit code into a 3-bit backlight level. Bits 2:0 of the code come from writes to a dedicated high-bank register, and bits 18:16 follow output bits 18:16 when the output high half is written. Two output bits are brought out as the serial data and clock lines of a software-driven two-wire bus.

Top module: `gpio_split_half`

## Requirements
- R1: After reset both input halves read 0xFFFF. Output, rising enable, falling enable, status and the brightness code read zero, `irq` is low, `pin_out` is zero and `bright` is 7.
- R2: A write with `wr_en` at offset 0x00C (output), 0x014 (falling enable) or 0x018 (rising enable) replaces bits 15:0 of that register. The same offset plus 0x500 replaces bits 31:16. The other half is unchanged. A read at either offset returns that half in `rdata` one clock after `rd_en`.
- R3: `pin_in` passes through a two-flop synchroniser. The input register is readable at 0x010 (bits 15:0) and 0x510 (bits 31:16) and follows `pin_in` within three clocks.
- R4: When the synchronised level of a pin changes, the edge qualifies if the new level is 1 and the pin's rising-enable bit is set, or if the new level is 0 and its falling-enable bit is set. A qualifying edge raises `irq`. An edge that does not qualify leaves `irq` and status unchanged.
- R5: A qualifying edge overwrites the status register with a mask holding only that pin's bit. Status is readable at 0x020 (bits 15:0) and 0x520 (bits 31:16). If several pins qualify in the same clock, the lowest-numbered pin is recorded.
- R6: A read of either status half returns the value held before the read, then clears the whole status register and lowers `irq`. If a qualifying edge lands in the same clock as the read, the new edge is kept and `irq` stays high.
- R7: A write at offset 0x508 stores `wdata[2:0]` into brightness code bits 2:0. A write to the output high half copies output bits 18:16 into code bits 18:16. Code bits 15:3 are always zero. A read of 0x508 returns code bits 2:0 with zeros above.
- R8: `bright` decodes the code: 0x00007 gives 0, 0x20000 gives 1, 0x20001 gives 2, 0x40000 gives 3, 0x10006 gives 4, 0x20005 gives 5, 0x40003 gives 6, and any other code gives 7. `bright` is registered and settles two clocks after the write.
- R9: `pin_out` equals the output register. `ser_data` equals output bit 29 and `ser_clk` equals output bit 30.
- R10: Writes to offsets outside the map, and writes to the input or status offsets, change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 16 | Write data for one half |
| rdata | output | 16 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output register to the pins |
| irq | output | 1 | Edge interrupt, high until status is read |
| bright | output | 3 | Decoded backlight level, bit i on line i |
| ser_data | output | 1 | Serial data line (output bit 29) |
| ser_clk | output | 1 | Serial clock line (output bit 30) |

## Verification
The bench walks every pin in both edge directions, each time with only the opposite direction enabled first. A design that mixed up the two enable masks, or that took its edge from the wrong synchroniser stage, would raise `irq` on the disabled edge or report the wrong one-hot bit. It changes three pins in the same clock to check the lowest-index priority. It also lines a status read up with the clock in which a new edge lands. A design that let the clear win would lose that interrupt. All 64 reachable brightness codes are swept against an independently computed level, together with the serial line bits. This would expose a swapped code field, a decode that is off by one entry, or a high-half write that disturbs the low half.

// File: rtl/gpio_sh_pkg.sv
package gpio_sh_pkg;

  localparam int ADDR_W  = 12;
  localparam int LVL_W   = 3;
  localparam int CODE_W  = 19;
  localparam int CODE_HI = 16;

  localparam logic [ADDR_W-1:0] OFS_OUT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_IN  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_FEN = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_REN = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_STS = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_HI  = 12'h500;
  localparam logic [ADDR_W-1:0] OFS_BOE = 12'h508;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_OUT_LO, RS_OUT_HI,
    RS_IN_LO,  RS_IN_HI,
    RS_FEN_LO, RS_FEN_HI,
    RS_REN_LO, RS_REN_HI,
    RS_STS_LO, RS_STS_HI,
    RS_BOE_HI
  } reg_sel_e;

  function automatic reg_sel_e sel_of(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFS_OUT:          s = RS_OUT_LO;
      OFS_OUT + OFS_HI: s = RS_OUT_HI;
      OFS_IN:           s = RS_IN_LO;
      OFS_IN + OFS_HI:  s = RS_IN_HI;
      OFS_FEN:          s = RS_FEN_LO;
      OFS_FEN + OFS_HI: s = RS_FEN_HI;
      OFS_REN:          s = RS_REN_LO;
      OFS_REN + OFS_HI: s = RS_REN_HI;
      OFS_STS:          s = RS_STS_LO;
      OFS_STS + OFS_HI: s = RS_STS_HI;
      OFS_BOE:          s = RS_BOE_HI;
      default:          s = RS_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [LVL_W-1:0] level_of(input logic [CODE_W-1:0] c);
    logic [LVL_W-1:0] l;
    case (c)
      19'h00007: l = 3'd0;
      19'h20000: l = 3'd1;
      19'h20001: l = 3'd2;
      19'h40000: l = 3'd3;
      19'h10006: l = 3'd4;
      19'h20005: l = 3'd5;
      19'h40003: l = 3'd6;
      default:   l = 3'd7;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/gpio_sh_sync.sv
module gpio_sh_sync #(
  parameter int WIDTH = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '1;
        else if (g == 0) stage_q[g] <= d;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_sh_edge.sv
module gpio_sh_edge #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] in_q,
  output logic [WIDTH-1:0] status_q,
  output logic             irq_q
);
  logic [WIDTH-1:0] changed;
  logic [WIDTH-1:0] qual;
  logic [WIDTH-1:0] first;
  logic             any_qual;

  always_comb begin
    changed  = sync_in ^ in_q;
    qual     = changed & ((sync_in & rise_en) | (~sync_in & fall_en));
    first    = qual & (~qual + 1'b1);
    any_qual = |qual;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q     <= '1;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      in_q <= sync_in;
      if (any_qual) begin
        status_q <= first;
        irq_q    <= 1'b1;
      end else if (rd_clr) begin
        status_q <= '0;
        irq_q    <= 1'b0;
      end
    end
  end

  // R5
  status_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(status_q));

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clr && !any_qual |=> status_q == '0 && !irq_q);

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_qual && !rd_clr |=> $stable(status_q) && $stable(irq_q));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    any_qual && rd_clr |=> irq_q && status_q != '0);
endmodule

// File: rtl/gpio_sh_regs.sv
module gpio_sh_regs
  import gpio_sh_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int BR_LSB = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]   rdata,
  input  logic [2*HALF_W-1:0] in_q,
  input  logic [2*HALF_W-1:0] status_q,
  output logic [2*HALF_W-1:0] out_q,
  output logic [2*HALF_W-1:0] fen_q,
  output logic [2*HALF_W-1:0] ren_q,
  output logic                rd_clr,
  output logic [LVL_W-1:0]    bright_q
);
  localparam int PIN_W  = 2 * HALF_W;
  localparam int MID_W  = CODE_HI - LVL_W;
  localparam int BR_OFS = BR_LSB - HALF_W;

  reg_sel_e         sel;
  logic [LVL_W-1:0] blo_q;
  logic [LVL_W-1:0] bhi_q;
  logic [CODE_W-1:0] code;

  assign sel    = sel_of(addr);
  assign rd_clr = rd_en && (sel == RS_STS_LO || sel == RS_STS_HI);
  assign code   = {bhi_q, {MID_W{1'b0}}, blo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      fen_q <= '0;
      ren_q <= '0;
      blo_q <= '0;
      bhi_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RS_OUT_LO: out_q[HALF_W-1:0] <= wdata;
        RS_OUT_HI: begin
          out_q[PIN_W-1:HALF_W] <= wdata;
          bhi_q <= wdata[BR_OFS +: LVL_W];
        end
        RS_FEN_LO: fen_q[HALF_W-1:0]     <= wdata;
        RS_FEN_HI: fen_q[PIN_W-1:HALF_W] <= wdata;
        RS_REN_LO: ren_q[HALF_W-1:0]     <= wdata;
        RS_REN_HI: ren_q[PIN_W-1:HALF_W] <= wdata;
        RS_BOE_HI: blo_q <= wdata[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bright_q <= '1;
    else     bright_q <= level_of(code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        RS_OUT_LO: rdata <= out_q[HALF_W-1:0];
        RS_OUT_HI: rdata <= out_q[PIN_W-1:HALF_W];
        RS_IN_LO:  rdata <= in_q[HALF_W-1:0];
        RS_IN_HI:  rdata <= in_q[PIN_W-1:HALF_W];
        RS_FEN_LO: rdata <= fen_q[HALF_W-1:0];
        RS_FEN_HI: rdata <= fen_q[PIN_W-1:HALF_W];
        RS_REN_LO: rdata <= ren_q[HALF_W-1:0];
        RS_REN_HI: rdata <= ren_q[PIN_W-1:HALF_W];
        RS_STS_LO: rdata <= status_q[HALF_W-1:0];
        RS_STS_HI: rdata <= status_q[PIN_W-1:HALF_W];
        RS_BOE_HI: rdata <= {{(HALF_W-LVL_W){1'b0}}, blo_q};
        default:   rdata <= '0;
      endcase
    end
  end

  // R2
  lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel == RS_OUT_LO |=>
      out_q[HALF_W-1:0] == $past(wdata) &&
      out_q[PIN_W-1:HALF_W] == $past(out_q[PIN_W-1:HALF_W]));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && (sel == RS_NONE || sel == RS_IN_LO || sel == RS_STS_HI) |=>
      $stable(out_q) && $stable(fen_q) && $stable(ren_q) &&
      $stable(blo_q) && $stable(bhi_q));

  // R7
  oe_code_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && sel == RS_BOE_HI |=> blo_q == $past(wdata[LVL_W-1:0]));
endmodule

// File: rtl/gpio_split_half.sv
module gpio_split_half
  import gpio_sh_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int SYNC_N  = 2,
  parameter int BR_LSB  = 16,
  parameter int SDA_BIT = 29,
  parameter int SCL_BIT = 30
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic        irq,
  output logic [2:0]  bright,
  output logic        ser_data,
  output logic        ser_clk
);
  localparam int PIN_W = 2 * HALF_W;

  logic [PIN_W-1:0] sync_lvl;
  logic [PIN_W-1:0] in_q;
  logic [PIN_W-1:0] status_q;
  logic [PIN_W-1:0] out_q;
  logic [PIN_W-1:0] fen_q;
  logic [PIN_W-1:0] ren_q;
  logic             rd_clr;

  gpio_sh_sync #(.WIDTH(PIN_W), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (sync_lvl)
  );

  gpio_sh_edge #(.WIDTH(PIN_W)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .sync_in  (sync_lvl),
    .rise_en  (ren_q),
    .fall_en  (fen_q),
    .rd_clr   (rd_clr),
    .in_q     (in_q),
    .status_q (status_q),
    .irq_q    (irq)
  );

  gpio_sh_regs #(.HALF_W(HALF_W), .BR_LSB(BR_LSB)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .in_q     (in_q),
    .status_q (status_q),
    .out_q    (out_q),
    .fen_q    (fen_q),
    .ren_q    (ren_q),
    .rd_clr   (rd_clr),
    .bright_q (bright)
  );

  assign pin_out  = out_q;
  assign ser_data = out_q[SDA_BIT];
  assign ser_clk  = out_q[SCL_BIT];

  // R4
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> status_q != '0);
endmodule

// File: tb/gpio_split_half_bench.sv
module gpio_split_half_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] pin_in = '1;
  logic [31:0] pin_out;
  logic        irq;
  logic [2:0]  bright;
  logic        ser_data;
  logic        ser_clk;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_split_half u_gpio_split_half (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .irq(irq), .bright(bright), .ser_data(ser_data), .ser_clk(ser_clk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] exp_level(input logic [18:0] c);
    if (c == 19'h00007) return 3'd0;
    if (c == 19'h20000) return 3'd1;
    if (c == 19'h20001) return 3'd2;
    if (c == 19'h40000) return 3'd3;
    if (c == 19'h10006) return 3'd4;
    if (c == 19'h20005) return 3'd5;
    if (c == 19'h40003) return 3'd6;
    return 3'd7;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #600000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] d;
    waitn(4);
    rst = 1'b0;
    waitn(1);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 bright", bright, 7);
    chk("R1 pin_out", pin_out, 0);
    rd(12'h010, d); chk("R1 in lo", d, 16'hFFFF);
    rd(12'h510, d); chk("R1 in hi", d, 16'hFFFF);
    rd(12'h00C, d); chk("R1 out lo", d, 0);
    rd(12'h50C, d); chk("R1 out hi", d, 0);
    rd(12'h014, d); chk("R1 fen lo", d, 0);
    rd(12'h518, d); chk("R1 ren hi", d, 0);
    rd(12'h020, d); chk("R1 sts lo", d, 0);
    rd(12'h508, d); chk("R1 code", d, 0);

    // R2 half writes
    wr(12'h00C, 16'hA5A5); waitn(1);
    chk("R2 out lo write", pin_out, 32'h0000A5A5);
    wr(12'h50C, 16'h1230); waitn(1);
    chk("R2 out hi write", pin_out, 32'h1230A5A5);
    wr(12'h00C, 16'h5A5A); waitn(1);
    chk("R2 lo keeps hi", pin_out, 32'h12305A5A);
    rd(12'h50C, d); chk("R2 out hi read", d, 16'h1230);
    wr(12'h014, 16'h00F0); wr(12'h514, 16'h0F00);
    rd(12'h014, d); chk("R2 fen lo", d, 16'h00F0);
    rd(12'h514, d); chk("R2 fen hi", d, 16'h0F00);
    wr(12'h018, 16'h1111); wr(12'h518, 16'h2222);
    rd(12'h018, d); chk("R2 ren lo", d, 16'h1111);
    rd(12'h518, d); chk("R2 ren hi", d, 16'h2222);

    // R10 ignored writes and unmapped reads
    wr(12'h000, 16'hFFFF); wr(12'h024, 16'hFFFF); wr(12'h800, 16'hFFFF);
    wr(12'h010, 16'h0000); wr(12'h520, 16'hFFFF);
    waitn(1);
    chk("R10 out stable", pin_out, 32'h12305A5A);
    rd(12'h014, d); chk("R10 fen stable", d, 16'h00F0);
    rd(12'h518, d); chk("R10 ren stable", d, 16'h2222);
    rd(12'h010, d); chk("R10 in not writable", d, 16'hFFFF);
    rd(12'h520, d); chk("R10 sts not writable", d, 0);
    rd(12'h024, d); chk("R10 unmapped read", d, 0);
    rd(12'h508, d); chk("R10 code stable", d, 0);
    chk("R10 irq", irq, 0);

    // R3 input tracking (enables off)
    wr(12'h014, 0); wr(12'h514, 0); wr(12'h018, 0); wr(12'h518, 0);
    pin_in = 32'h0F0F_3C3C; waitn(4);
    rd(12'h010, d); chk("R3 in lo", d, 16'h3C3C);
    rd(12'h510, d); chk("R3 in hi", d, 16'h0F0F);
    chk("R3 no irq when disabled", irq, 0);
    pin_in = '1; waitn(4);

    // R4 R5 R6 rising sweep
    wr(12'h018, 16'hFFFF); wr(12'h518, 16'hFFFF);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] m;
      m = 32'h1 << i;
      pin_in[i] = 1'b0; waitn(4);
      chk("R4 falling ignored", irq, 0);
      pin_in[i] = 1'b1; waitn(4);
      chk("R4 rising irq", irq, 1);
      rd(i < 16 ? 12'h020 : 12'h520, d);
      chk("R5 rising status", d, i < 16 ? m[15:0] : m[31:16]);
      chk("R6 irq cleared", irq, 0);
      rd(i < 16 ? 12'h520 : 12'h020, d);
      chk("R6 status cleared", d, 0);
    end

    // R4 R5 falling sweep
    wr(12'h018, 0); wr(12'h518, 0);
    wr(12'h014, 16'hFFFF); wr(12'h514, 16'hFFFF);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] m;
      m = 32'h1 << i;
      pin_in[i] = 1'b0; waitn(4);
      chk("R4 falling irq", irq, 1);
      rd(i < 16 ? 12'h020 : 12'h520, d);
      chk("R5 falling status", d, i < 16 ? m[15:0] : m[31:16]);
      pin_in[i] = 1'b1; waitn(4);
      chk("R4 rising ignored", irq, 0);
      rd(12'h020, d); chk("R4 status unchanged lo", d, 0);
      rd(12'h520, d); chk("R4 status unchanged hi", d, 0);
    end

    // R5 simultaneous edges
    wr(12'h014, 0); wr(12'h514, 0);
    wr(12'h018, 16'hFFFF); wr(12'h518, 16'hFFFF);
    pin_in[3] = 0; pin_in[5] = 0; pin_in[20] = 0; waitn(4);
    chk("R5 setup quiet", irq, 0);
    pin_in[3] = 1; pin_in[5] = 1; pin_in[20] = 1; waitn(4);
    chk("R5 multi irq", irq, 1);
    rd(12'h020, d); chk("R5 lowest pin wins", d, 16'h0008);
    chk("R5 cleared", irq, 0);

    // R6 clear collides with new edge
    pin_in[1] = 0; waitn(4); pin_in[1] = 1; waitn(4);
    chk("R6 pre irq", irq, 1);
    pin_in[4] = 0; waitn(4);
    pin_in[4] = 1; waitn(2);
    rd(12'h020, d); chk("R6 read returns old", d, 16'h0002);
    chk("R6 edge wins irq", irq, 1);
    rd(12'h020, d); chk("R6 new status kept", d, 16'h0010);
    chk("R6 final clear", irq, 0);

    // R7 R8 R9 brightness and serial sweep
    for (int oe = 0; oe < 8; oe++) begin
      for (int ob = 0; ob < 8; ob++) begin
        logic [18:0] code;
        logic [15:0] hi;
        hi = {1'b0, oe[1], oe[0], 10'h0, ob[2:0]};
        wr(12'h508, {13'h1ABC, oe[2:0]});
        wr(12'h50C, hi);
        waitn(2);
        code = {ob[2:0], 13'h0, oe[2:0]};
        chk("R8 level", bright, exp_level(code));
        chk("R9 ser_data", ser_data, oe[0]);
        chk("R9 ser_clk", ser_clk, oe[1]);
        chk("R9 pin_out hi", pin_out[31:16], hi);
        rd(12'h508, d); chk("R7 code lo read", d, oe);
      end
    end
    // R7 low output half does not touch the code
    wr(12'h508, 16'h0007); wr(12'h50C, 16'h0000); wr(12'h00C, 16'hFFFF); waitn(2);
    chk("R7 code 7 level", bright, 0);

    summary();
  end
endmodule